// File: doc/BRIEF.md
# Vector Integer Pack/Unpack Unit

This unit moves integer data between a packed form (four 8-bit values or two 16-bit values in a 32-bit word) and a vector of 32-bit fixed-point lanes. It works in both directions. Expansion spreads the bytes or halfwords of one or two source words across a pair or quad of lanes. Compression gathers a pair or quad of lanes back into one or two packed words. The unsigned modes place the value so that its top bit sits at lane bit 30 and clamp negative lanes to zero. The signed modes place the value at lane bit 31.

A direction bit and a 2-bit function code select one of eight conversions. A size input gives the number of source lanes, and the unit reports the number of valid result lanes so that a downstream writer can skip the rest. The datapath is combinational and ends in a single output register. Each accepted input yields a result with a valid flag exactly one clock later.

Top module: `vpack_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `out_valid`, `out_data` and `out_size` (all zero) on that edge.
- R2: `out_valid` is high on the cycle after `in_valid` was high, and low otherwise. While `in_valid` is low, `out_data` and `out_size` keep their previous values whatever the other inputs do.
- R3: Expand (`in_dir`=0) with function 0 (unsigned byte) takes byte k of lane 0, counting from the low byte, and writes (b*0x01010101)>>1 to lane k. The result size is 3 (four lanes).
- R4: Expand with function 1 (signed byte) writes byte k of lane 0 into bits 31:24 of lane k, with bits 23:0 zero. The result size is 3.
- R5: Expand with function 2 (unsigned half) takes each source word i. It writes the low half, shifted left by 15, to lane 2i, and the high half, moved to bits 30:15, to lane 2i+1. A size of 0 uses word 0 only and gives result size 1. Any other size uses words 0 and 1 and gives result size 3.
- R6: Expand with function 3 (signed half) writes the low half to bits 31:16 of lane 2i and the high half in place to lane 2i+1, with zero below. Words used and result sizes follow R5.
- R7: Compress (`in_dir`=1) with function 0 clamps each of lanes 0..3 to zero if bit 31 is set. It then writes bits 30:23 of lane i into byte i of result lane 0. The result size is 0.
- R8: Compress with function 1 writes bits 31:24 of lane i into byte i of result lane 0. The result size is 0.
- R9: Compress with function 2 clamps negative lanes to zero. It packs bits 30:15 of lane 2j into the low half and bits 30:15 of lane 2j+1 into the high half of result lane j. A size of 3 gives two result lanes (size 1). Any other size gives one result lane (size 0).
- R10: Compress with function 3 packs bits 31:16 of lanes 2j and 2j+1 into the low and high halves of result lane j. Result sizes follow R9.
- R11: The size codes are 0=one, 1=two, 2=three and 3=four lanes. Lane k is at bits 32k+31:32k. Result lanes at or above the reported count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| in_dir | input | 1 | 0 = expand, 1 = compress |
| in_func | input | 2 | 0 unsigned byte, 1 signed byte, 2 unsigned half, 3 signed half |
| in_size | input | 2 | Source lane count minus one |
| in_data | input | 128 | Source lanes, lane k at bits 32k+31:32k |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| out_data | output | 128 | Result lanes |
| out_size | output | 2 | Result lane count minus one |

## Verification
Expansion is driven with bytes that mix set and clear top bits, such as 0x80, 0xFF, 0x01 and 0x17. These show the bit replication of the unsigned form against the plain placement of the signed form, and expose any byte reordering. Compression is fed lanes that are all-ones, lanes with only bit 31 set, and large positive values. Together they separate clamping from bit-31 truncation and catch an off-by-one shift. Each halfword mode is run at every size code, which checks both the single/pair split and the zeroing of unused lanes. Idle cycles with changing inputs confirm that the output register holds its value.

// File: rtl/vpack_pkg.sv
package vpack_pkg;
  parameter int LANES  = 4;
  parameter int LANE_W = 32;
  parameter int BYTE_W = 8;
  parameter int HALF_W = 16;
  localparam int VEC_W   = LANES * LANE_W;
  localparam int HALVES  = LANES / 2;

  typedef logic [LANES-1:0][LANE_W-1:0] lane_vec_t;

  typedef enum logic [1:0] {
    LEN_ONE   = 2'd0,
    LEN_TWO   = 2'd1,
    LEN_THREE = 2'd2,
    LEN_FOUR  = 2'd3
  } len_t;

  typedef enum logic [1:0] {
    FN_UBYTE = 2'd0,
    FN_SBYTE = 2'd1,
    FN_UHALF = 2'd2,
    FN_SHALF = 2'd3
  } fn_t;
endpackage

// File: rtl/vpack_expand.sv
module vpack_expand
  import vpack_pkg::*;
(
  input  fn_t       func,
  input  len_t      size,
  input  lane_vec_t src,
  output lane_vec_t res,
  output len_t      res_len
);
  lane_vec_t ub_lane, sb_lane, uh_lane, sh_lane;
  logic      two_words;

  assign two_words = (size != LEN_ONE);

  // byte paths: one lane per byte of source word 0
  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [BYTE_W-1:0] b;
    assign b = src[0][k*BYTE_W +: BYTE_W];
    assign ub_lane[k] = {1'b0, b, b, b, b[BYTE_W-1:1]};
    assign sb_lane[k] = {b, {(LANE_W-BYTE_W){1'b0}}};
  end

  // halfword paths: word j feeds lanes 2j and 2j+1
  for (genvar j = 0; j < HALVES; j++) begin : g_half
    logic [HALF_W-1:0] lo, hi;
    logic              use_word;
    assign lo       = src[j][HALF_W-1:0];
    assign hi       = src[j][LANE_W-1:HALF_W];
    assign use_word = (j == 0) || two_words;
    assign uh_lane[2*j]   = use_word ? {1'b0, lo, {(LANE_W-HALF_W-1){1'b0}}} : '0;
    assign uh_lane[2*j+1] = use_word ? {1'b0, hi, {(LANE_W-HALF_W-1){1'b0}}} : '0;
    assign sh_lane[2*j]   = use_word ? {lo, {(LANE_W-HALF_W){1'b0}}} : '0;
    assign sh_lane[2*j+1] = use_word ? {hi, {(LANE_W-HALF_W){1'b0}}} : '0;
  end

  always_comb begin
    unique case (func)
      FN_UBYTE: begin res = ub_lane; res_len = LEN_FOUR; end
      FN_SBYTE: begin res = sb_lane; res_len = LEN_FOUR; end
      FN_UHALF: begin res = uh_lane; res_len = two_words ? LEN_FOUR : LEN_TWO; end
      default:  begin res = sh_lane; res_len = two_words ? LEN_FOUR : LEN_TWO; end
    endcase
  end
endmodule

// File: rtl/vpack_compress.sv
module vpack_compress
  import vpack_pkg::*;
(
  input  fn_t       func,
  input  len_t      size,
  input  lane_vec_t src,
  output lane_vec_t res,
  output len_t      res_len
);
  lane_vec_t                   pos;
  logic [LANE_W-1:0]           ub_word, sb_word;
  logic [HALVES-1:0][LANE_W-1:0] uh_word, sh_word;
  logic                        wide;

  assign wide = (size == LEN_FOUR);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign pos[k] = src[k][LANE_W-1] ? '0 : src[k];
    assign ub_word[k*BYTE_W +: BYTE_W] = pos[k][LANE_W-2 -: BYTE_W];
    assign sb_word[k*BYTE_W +: BYTE_W] = src[k][LANE_W-1 -: BYTE_W];
  end

  for (genvar j = 0; j < HALVES; j++) begin : g_pair
    assign uh_word[j] = {pos[2*j+1][LANE_W-2 -: HALF_W], pos[2*j][LANE_W-2 -: HALF_W]};
    assign sh_word[j] = {src[2*j+1][LANE_W-1 -: HALF_W], src[2*j][LANE_W-1 -: HALF_W]};
  end

  always_comb begin
    res     = '0;
    res_len = LEN_ONE;
    unique case (func)
      FN_UBYTE: res[0] = ub_word;
      FN_SBYTE: res[0] = sb_word;
      FN_UHALF: begin
        res[0]  = uh_word[0];
        res[1]  = wide ? uh_word[1] : '0;
        res_len = wide ? LEN_TWO : LEN_ONE;
      end
      default: begin
        res[0]  = sh_word[0];
        res[1]  = wide ? sh_word[1] : '0;
        res_len = wide ? LEN_TWO : LEN_ONE;
      end
    endcase
  end

  // R7
  always_comb begin
    if (func == FN_UBYTE && src[0][LANE_W-1])
      ubyte_clamp_chk: assert (res[0][BYTE_W-1:0] == '0);
  end
endmodule

// File: rtl/vpack_unit.sv
module vpack_unit
  import vpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_dir,
  input  logic [1:0]        in_func,
  input  logic [1:0]        in_size,
  input  logic [VEC_W-1:0]  in_data,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_data,
  output logic [1:0]        out_size
);
  lane_vec_t src, exp_res, cmp_res, sel_res;
  len_t      exp_len, cmp_len, sel_len;

  assign src = lane_vec_t'(in_data);

  vpack_expand u_expand (
    .func    (fn_t'(in_func)),
    .size    (len_t'(in_size)),
    .src     (src),
    .res     (exp_res),
    .res_len (exp_len)
  );

  vpack_compress u_compress (
    .func    (fn_t'(in_func)),
    .size    (len_t'(in_size)),
    .src     (src),
    .res     (cmp_res),
    .res_len (cmp_len)
  );

  assign sel_res = in_dir ? cmp_res : exp_res;
  assign sel_len = in_dir ? cmp_len : exp_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_size  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= sel_res;
        out_size <= sel_len;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_size)));

  // R11
  single_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_size == LEN_ONE) |-> out_data[VEC_W-1:LANE_W] == '0);

  // R8
  sbyte_pack_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_dir && in_func == FN_SBYTE) |=>
      out_data[BYTE_W-1:0] == $past(in_data[LANE_W-1 -: BYTE_W]));

  // R3
  ubyte_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dir && in_func == FN_UBYTE) |=>
      (!out_data[LANE_W-1] && !out_data[2*LANE_W-1] &&
       !out_data[3*LANE_W-1] && !out_data[4*LANE_W-1]));
endmodule

// File: tb/vpack_unit_tb.sv
module vpack_unit_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_dir;
  logic [1:0]   in_func;
  logic [1:0]   in_size;
  logic [127:0] in_data;
  logic         out_valid;
  logic [127:0] out_data;
  logic [1:0]   out_size;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [127:0] q_data[$];
  logic [1:0]   q_size[$];
  string        q_tag[$];
  logic [127:0] last_data;
  logic [1:0]   last_size;

  always #10 clk = ~clk;

  vpack_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
    .in_func(in_func), .in_size(in_size), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_size(out_size)
  );

  function automatic logic [31:0] lane(input logic [127:0] v, input int k);
    return v[k*32 +: 32];
  endfunction

  function automatic logic [31:0] clamp(input logic [31:0] x);
    return ($signed(x) < 0) ? 32'd0 : x;
  endfunction

  task automatic model(input logic dir, input logic [1:0] fn, input logic [1:0] sz,
                       input logic [127:0] d, output logic [127:0] r, output logic [1:0] rs);
    logic [31:0] t;
    int nw;
    r = '0;
    if (!dir) begin
      case (fn)
        2'd0: begin
          for (int k = 0; k < 4; k++) begin
            t = ((lane(d, 0) >> (8*k)) & 32'hFF) * 32'h01010101;
            r[k*32 +: 32] = t >> 1;
          end
          rs = 2'd3;
        end
        2'd1: begin
          for (int k = 0; k < 4; k++) r[k*32 +: 32] = ((lane(d, 0) >> (8*k)) & 32'hFF) << 24;
          rs = 2'd3;
        end
        default: begin
          nw = (sz == 2'd0) ? 1 : 2;
          for (int i = 0; i < nw; i++) begin
            if (fn == 2'd2) begin
              r[(2*i)*32 +: 32]   = (lane(d, i) & 32'hFFFF) << 15;
              r[(2*i+1)*32 +: 32] = (lane(d, i) & 32'hFFFF0000) >> 1;
            end else begin
              r[(2*i)*32 +: 32]   = (lane(d, i) & 32'hFFFF) << 16;
              r[(2*i+1)*32 +: 32] = lane(d, i) & 32'hFFFF0000;
            end
          end
          rs = (nw == 1) ? 2'd1 : 2'd3;
        end
      endcase
    end else begin
      case (fn)
        2'd0: begin
          for (int k = 0; k < 4; k++) r[k*8 +: 8] = 8'((clamp(lane(d, k)) >> 23) & 32'hFF);
          rs = 2'd0;
        end
        2'd1: begin
          for (int k = 0; k < 4; k++) r[k*8 +: 8] = 8'(lane(d, k) >> 24);
          rs = 2'd0;
        end
        default: begin
          nw = (sz == 2'd3) ? 2 : 1;
          for (int j = 0; j < nw; j++) begin
            if (fn == 2'd2) begin
              r[j*32 +: 16]      = 16'(clamp(lane(d, 2*j)) >> 15);
              r[j*32 + 16 +: 16] = 16'(clamp(lane(d, 2*j+1)) >> 15);
            end else begin
              r[j*32 +: 16]      = 16'(lane(d, 2*j) >> 16);
              r[j*32 + 16 +: 16] = 16'(lane(d, 2*j+1) >> 16);
            end
          end
          rs = (nw == 2) ? 2'd1 : 2'd0;
        end
      endcase
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [129:0] act,
                       input logic [129:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic dir, input logic [1:0] fn, input logic [1:0] sz,
                      input logic [127:0] d, input string tag);
    logic [127:0] r;
    logic [1:0]   rs;
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_func = fn; in_size = sz; in_data = d;
    model(dir, fn, sz, d, r, rs);
    q_data.push_back(r); q_size.push_back(rs); q_tag.push_back(tag);
    last_data = r; last_size = rs;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_dir   = ~in_dir;
      in_func  = in_func + 2'd1;
      in_data  = {in_data[126:0], ~in_data[127]};
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R2 unexpected result", {out_size, out_data}, '0);
      end else begin
        logic [127:0] ed;
        logic [1:0]   es;
        string        tg;
        ed = q_data.pop_front(); es = q_size.pop_front(); tg = q_tag.pop_front();
        check(out_data == ed && out_size == es, tg, {out_size, out_data}, {es, ed});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_dir = 1'b0; in_func = 2'd0; in_size = 2'd0;
    in_data = {4{32'hDEAD_BEEF}};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", {129'd0, out_valid}, '0);
    check(out_data == '0, "R1 out_data", {2'b0, out_data}, '0);
    check(out_size == '0, "R1 out_size", {128'd0, out_size}, '0);
    rst = 1'b0;

    // R3 unsigned byte expand, two byte patterns
    send(1'b0, 2'd0, 2'd0, {96'hFFFF, 32'h80FF_0117}, "R3 ubyte expand A");
    send(1'b0, 2'd0, 2'd3, {96'h0,    32'h7F40_C302}, "R3 ubyte expand B");
    // R4 signed byte expand
    send(1'b0, 2'd1, 2'd0, {96'hABCD, 32'h80FF_0117}, "R4 sbyte expand");
    // R5 unsigned half expand, all sizes
    for (int s = 0; s < 4; s++)
      send(1'b0, 2'd2, 2'(s), {32'h1111_2222, 32'h3333_4444, 32'hFFFF_8001, 32'h8000_7FFF},
           "R5 uhalf expand");
    // R6 signed half expand, all sizes
    for (int s = 0; s < 4; s++)
      send(1'b0, 2'd3, 2'(s), {32'h1111_2222, 32'h3333_4444, 32'hFFFF_8001, 32'h8000_7FFF},
           "R6 shalf expand");
    // R7 unsigned byte compress: negative, max positive, mid values
    send(1'b1, 2'd0, 2'd3, {32'h4080_0000, 32'h0080_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
         "R7 ubyte compress clamp");
    send(1'b1, 2'd0, 2'd3, {32'h8000_0000, 32'h3F80_0000, 32'h0000_0000, 32'h8123_4567},
         "R7 ubyte compress B");
    // R8 signed byte compress
    send(1'b1, 2'd1, 2'd3, {32'h4080_0000, 32'h0080_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
         "R8 sbyte compress");
    // R9 unsigned half compress, all sizes
    for (int s = 0; s < 4; s++)
      send(1'b1, 2'd2, 2'(s), {32'h7FFF_8000, 32'h8000_0001, 32'h0001_8000, 32'hFFFF_0000},
           "R9 uhalf compress");
    // R10 signed half compress, all sizes
    for (int s = 0; s < 4; s++)
      send(1'b1, 2'd3, 2'(s), {32'h7FFF_8000, 32'h8000_0001, 32'h0001_8000, 32'hFFFF_0000},
           "R10 shalf compress");
    // R11 upper lanes of a two-lane result must be zero
    send(1'b0, 2'd2, 2'd0, {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
         "R11 unused lanes zero");

    idle(6);
    // R2 hold while idle
    check(out_valid == 1'b0, "R2 idle valid", {129'd0, out_valid}, '0);
    check(out_data == last_data && out_size == last_size, "R2 idle hold",
          {out_size, out_data}, {last_size, last_data});
    check(q_data.size() == 0, "R2 all results seen", 130'(q_data.size()), '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule